// File: doc/BRIEF.md
# Stereo Streaming Biquad Filter

This block runs a second-order recursive (biquad) filter on a live stereo audio stream. Each input word carries a left and a right sample as signed 16-bit fixed-point values. The two channels are filtered independently: each keeps its own past inputs and past outputs. Both channels use one shared set of five coefficients. Every accepted word leaves as a filtered, saturated word on the output stream one clock later. The valid/ready handshake follows the usual streaming rules, so backpressure from downstream stalls the input without dropping a sample.

The coefficients arrive on plain input ports that control logic outside the block holds steady. They are read continuously. The result is only defined while they are not changing during streaming. A single output register is the only buffering. A two-state handshake machine sits on it: the state `OUT_EMPTY` means no result is waiting, and `OUT_FULL` means a result is waiting. The named transitions are:
- `LOAD` (empty to full): a beat is accepted.
- `DRAIN` (full to empty): the result is read and nothing new is accepted.
- `REFILL` (full to full): the result is read and a new beat is accepted in the same cycle.
- `STALL` (full to full): downstream is not ready.
- `IDLE` (empty to empty): nothing arrives.

Top module: `stereo_biquad`

## Requirements
- R1: Stream words are 32 bits wide. Bits [31:16] hold the left sample and bits [15:0] hold the right sample, on both input and output. Samples are signed Q1.15.
- R2: Each channel computes out = c0·x[n] + c1·x[n-1] + c2·x[n-2] − d1·y[n-1] − d2·y[n-2]. The terms c0, c1, c2, d1 and d2 are the signed 16-bit Q2.14 coefficient ports `coef_ff0`, `coef_ff1`, `coef_ff2`, `coef_fb1` and `coef_fb2`. Both channels use the same coefficients. The y terms are the channel's own earlier saturated outputs.
- R3: The full-precision sum is rounded half-up to Q1.15: add 8192, then shift arithmetically right by 14. For example, a sum of 8192 gives 1, a sum of 8191 gives 0, and a sum of −8193 gives −1.
- R4: A rounded result above 32767 leaves as 32767, and one below −32768 leaves as −32768. Results never wrap.
- R5: Each channel's history depends only on that channel's samples. A channel fed only zeros outputs zeros, whatever the other channel carries.
- R6: A beat accepted at a clock edge appears on `m_tdata`, with `m_tvalid` high, immediately after that same edge.
- R7: `s_tready` is high exactly when `m_tvalid` is low or `m_tready` is high.
- R8: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` hold their values.
- R9: Filter history advances only on an accepted beat. Input data present while `s_tvalid` is low, or while the input is stalled, has no effect on later outputs.
- R10: A synchronous active-high `rst` clears the history of both channels and drops `m_tvalid`.
- R11: `m_tlast` carries the `s_tlast` of the beat whose result is on `m_tdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | 32 | Input stereo word (left high, right low) |
| s_tvalid | input | 1 | Input word valid |
| s_tready | output | 1 | Block can take the input word |
| s_tlast | input | 1 | Input end-of-packet marker |
| m_tdata | output | 32 | Filtered stereo word |
| m_tvalid | output | 1 | Output word valid |
| m_tready | input | 1 | Downstream takes the output word |
| m_tlast | output | 1 | Output end-of-packet marker |
| coef_ff0 | input | 16 | Feed-forward coefficient for x[n], Q2.14 |
| coef_ff1 | input | 16 | Feed-forward coefficient for x[n-1], Q2.14 |
| coef_ff2 | input | 16 | Feed-forward coefficient for x[n-2], Q2.14 |
| coef_fb1 | input | 16 | Feedback coefficient for y[n-1], Q2.14 |
| coef_fb2 | input | 16 | Feedback coefficient for y[n-2], Q2.14 |

## Verification
The bench targets the rounding boundary at exactly half an LSB on both sides of zero. A design that truncated, or rounded symmetrically, would return 0 where 1 is due, or 0 where −1 is due. It drives gains near 2 into full-scale inputs: an adder that wraps instead of saturating would flip the sign of the result, and would then feed that wrong value back into the history. Random backpressure alternates with garbage on an idle input. This exposes a design that advanced its history on unaccepted data, changed a stalled output, or lost a beat during a read-and-accept cycle. A mid-stream reset with nonzero delay taps and a one-sided stereo signal exposes leftover history and any crosstalk between the channels.

// File: rtl/biquad_pkg.sv
package biquad_pkg;

    parameter int SAMP_W = 16;
    parameter int COEF_W = 16;
    parameter int FRAC_W = 14;
    parameter int ACC_W  = 36;

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef logic signed [COEF_W-1:0] coef_t;

    typedef struct packed {
        coef_t ff0;
        coef_t ff1;
        coef_t ff2;
        coef_t fb1;
        coef_t fb2;
    } coef_set_t;

    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_FULL  = 1'b1
    } out_state_e;

endpackage

// File: rtl/sat_round.sv
module sat_round #(
    parameter int IN_W  = 36,
    parameter int OUT_W = 16,
    parameter int SHIFT = 14
) (
    input  logic signed [IN_W-1:0]  acc,
    output logic signed [OUT_W-1:0] y
);
    localparam logic signed [IN_W-1:0] HALF =
        {{(IN_W-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};
    localparam logic signed [IN_W-1:0] MAXV =
        {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [IN_W-1:0] MINV =
        {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [IN_W-1:0] biased;
    logic signed [IN_W-1:0] scaled;

    always_comb begin
        biased = acc + HALF;
        scaled = biased >>> SHIFT;
        if (scaled > MAXV) begin
            y = MAXV[OUT_W-1:0];
        end else if (scaled < MINV) begin
            y = MINV[OUT_W-1:0];
        end else begin
            y = scaled[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/biquad_chan.sv
module biquad_chan
    import biquad_pkg::*;
#(
    parameter int S_W   = 16,
    parameter int C_W   = 16,
    parameter int F_W   = 14,
    parameter int A_W   = 36
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  advance,
    input  logic signed [S_W-1:0] x_in,
    input  coef_set_t             coefs,
    output logic signed [S_W-1:0] y_out
);
    localparam int P_W = S_W + C_W;

    logic signed [S_W-1:0] x_d1, x_d2, y_d1, y_d2;
    logic signed [P_W-1:0] p_ff0, p_ff1, p_ff2, p_fb1, p_fb2;
    logic signed [A_W-1:0] acc;

    always_comb begin
        p_ff0 = P_W'(x_in) * P_W'(coefs.ff0);
        p_ff1 = P_W'(x_d1) * P_W'(coefs.ff1);
        p_ff2 = P_W'(x_d2) * P_W'(coefs.ff2);
        p_fb1 = P_W'(y_d1) * P_W'(coefs.fb1);
        p_fb2 = P_W'(y_d2) * P_W'(coefs.fb2);
        acc   = A_W'(p_ff0) + A_W'(p_ff1) + A_W'(p_ff2)
              - A_W'(p_fb1) - A_W'(p_fb2);
    end

    sat_round #(
        .IN_W (A_W),
        .OUT_W(S_W),
        .SHIFT(F_W)
    ) u_sat (
        .acc(acc),
        .y  (y_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            x_d1 <= '0;
            x_d2 <= '0;
            y_d1 <= '0;
            y_d2 <= '0;
        end else if (advance) begin
            x_d1 <= x_in;
            x_d2 <= x_d1;
            y_d1 <= y_out;
            y_d2 <= y_d1;
        end
    end
endmodule

// File: rtl/stream_ctrl.sv
module stream_ctrl
    import biquad_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic take
);
    out_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OUT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        take      = 1'b0;
        state_d   = state_q;
        unique case (state_q)
            OUT_EMPTY: begin
                in_ready = 1'b1;
                take     = in_valid;
                if (in_valid) begin
                    state_d = OUT_FULL;
                end
            end
            OUT_FULL: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
                take      = in_valid && out_ready;
                if (out_ready && !in_valid) begin
                    state_d = OUT_EMPTY;
                end
            end
            default: state_d = OUT_EMPTY;
        endcase
    end
endmodule

// File: rtl/stereo_biquad.sv
module stereo_biquad
    import biquad_pkg::*;
#(
    parameter int CH_W   = SAMP_W,
    parameter int N_CH   = 2,
    parameter int DATA_W = CH_W * N_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic              s_tlast,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tlast,
    input  logic [COEF_W-1:0] coef_ff0,
    input  logic [COEF_W-1:0] coef_ff1,
    input  logic [COEF_W-1:0] coef_ff2,
    input  logic [COEF_W-1:0] coef_fb1,
    input  logic [COEF_W-1:0] coef_fb2
);
    logic              take;
    logic [DATA_W-1:0] filt_word;
    coef_set_t         coefs;

    assign coefs = '{ff0: coef_ff0, ff1: coef_ff1, ff2: coef_ff2,
                     fb1: coef_fb1, fb2: coef_fb2};

    stream_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (s_tvalid),
        .out_ready(m_tready),
        .in_ready (s_tready),
        .out_valid(m_tvalid),
        .take     (take)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        logic signed [CH_W-1:0] y_ch;
        biquad_chan #(
            .S_W(CH_W),
            .C_W(COEF_W),
            .F_W(FRAC_W),
            .A_W(ACC_W)
        ) u_chan (
            .clk    (clk),
            .rst    (rst),
            .advance(take),
            .x_in   (s_tdata[ch*CH_W +: CH_W]),
            .coefs  (coefs),
            .y_out  (y_ch)
        );
        assign filt_word[ch*CH_W +: CH_W] = y_ch;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_tdata <= '0;
            m_tlast <= 1'b0;
        end else if (take) begin
            m_tdata <= filt_word;
            m_tlast <= s_tlast;
        end
    end
endmodule

// File: rtl/stereo_biquad_chk.sv
module stereo_biquad_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              s_tvalid,
    input logic              s_tready,
    input logic              s_tlast,
    input logic [DATA_W-1:0] m_tdata,
    input logic              m_tvalid,
    input logic              m_tready,
    input logic              m_tlast
);
    // R7
    empty_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !m_tvalid |-> s_tready);

    // R7
    stall_block_chk: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |-> !s_tready);

    // R6
    one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && s_tready) |=> m_tvalid);

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    // R11
    last_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && s_tready) |=> (m_tlast == $past(s_tlast)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !m_tvalid);
endmodule

bind stereo_biquad stereo_biquad_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .s_tvalid(s_tvalid),
    .s_tready(s_tready),
    .s_tlast (s_tlast),
    .m_tdata (m_tdata),
    .m_tvalid(m_tvalid),
    .m_tready(m_tready),
    .m_tlast (m_tlast)
);

// File: tb/tb_stereo_biquad.sv
module tb_stereo_biquad;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic        s_tlast = 1'b0;
    logic [31:0] m_tdata;
    logic        m_tvalid;
    logic        m_tready = 1'b1;
    logic        m_tlast;
    logic [15:0] coef_ff0 = '0, coef_ff1 = '0, coef_ff2 = '0, coef_fb1 = '0, coef_fb2 = '0;

    typedef struct { logic [31:0] data; logic last; string tag; } item_t;
    item_t q[$];

    int checks = 0, fails = 0, cyc = 0, accept_cyc = -10;
    bit ready_mode = 0;
    bit done = 0;
    int hx1[2], hx2[2], hy1[2], hy2[2];

    always #10 clk = ~clk;

    stereo_biquad dut (
        .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tready(s_tready), .s_tlast(s_tlast), .m_tdata(m_tdata),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
        .coef_ff0(coef_ff0), .coef_ff1(coef_ff1), .coef_ff2(coef_ff2),
        .coef_fb1(coef_fb1), .coef_fb2(coef_fb2)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected < 100000", cyc);
            summary();
        end
    end

    always @(negedge clk) m_tready = ready_mode ? ($urandom_range(0, 2) != 0) : 1'b1;

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference per R2/R3/R4
    function automatic int ref_y(int x, int ch);
        longint acc;
        acc = longint'($signed(coef_ff0)) * x + longint'($signed(coef_ff1)) * hx1[ch]
            + longint'($signed(coef_ff2)) * hx2[ch] - longint'($signed(coef_fb1)) * hy1[ch]
            - longint'($signed(coef_fb2)) * hy2[ch];
        acc = (acc + 8192) >>> 14;
        if (acc > 32767) acc = 32767;
        if (acc < -32768) acc = -32768;
        return int'(acc);
    endfunction

    task automatic clear_model();
        for (int c = 0; c < 2; c++) begin hx1[c] = 0; hx2[c] = 0; hy1[c] = 0; hy2[c] = 0; end
    endtask

    // Driver: channel 1 = left = bits [31:16] (R1)
    task automatic send(int l, int r, bit last, string tag);
        item_t it;
        int xs[2];
        int ys[2];
        @(negedge clk);
        s_tdata  = {l[15:0], r[15:0]};
        s_tlast  = last;
        s_tvalid = 1'b1;
        #5;
        while (!s_tready) begin @(negedge clk); #5; end
        xs[0] = $signed(r[15:0]); xs[1] = $signed(l[15:0]);
        for (int c = 0; c < 2; c++) begin
            ys[c] = ref_y(xs[c], c);
            hx2[c] = hx1[c]; hx1[c] = xs[c]; hy2[c] = hy1[c]; hy1[c] = ys[c];
        end
        it.data = {ys[1][15:0], ys[0][15:0]};
        it.last = last;
        it.tag  = tag;
        q.push_back(it);
        accept_cyc = cyc;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s_tvalid = 1'b0;
            s_tdata  = $urandom;
            s_tlast  = $urandom_range(0, 1);
        end
    endtask

    task automatic drain();
        int guard = 0;
        idle(1);
        while (q.size() != 0 && guard < 1000) begin @(negedge clk); guard++; end
        idle(2);
    endtask

    task automatic set_coefs(int f0, int f1, int f2, int b1, int b2);
        coef_ff0 = f0[15:0]; coef_ff1 = f1[15:0]; coef_ff2 = f2[15:0];
        coef_fb1 = b1[15:0]; coef_fb2 = b2[15:0];
    endtask

    // Monitor / scoreboard
    logic [31:0] held_data;
    logic        held_last;
    bit          was_stalled = 0;
    always begin
        @(negedge clk);
        #5;
        if (!rst) begin
            check(s_tready == (!m_tvalid || m_tready), "R7", {31'b0, s_tready}, {31'b0, (!m_tvalid || m_tready)});
            if (cyc == accept_cyc + 1)
                check(m_tvalid === 1'b1, "R6", {31'b0, m_tvalid}, 32'd1);
            if (was_stalled)
                check(m_tvalid && m_tdata == held_data && m_tlast == held_last, "R8", m_tdata, held_data);
            if (m_tvalid && m_tready) begin
                if (q.size() == 0) begin
                    check(1'b0, "R6 unexpected beat", m_tdata, 32'hx);
                end else begin
                    item_t e;
                    e = q.pop_front();
                    check(m_tdata === e.data, e.tag, m_tdata, e.data);
                    check(m_tlast === e.last, "R11", {31'b0, m_tlast}, {31'b0, e.last});
                end
            end
            was_stalled = m_tvalid && !m_tready;
            held_data = m_tdata;
            held_last = m_tlast;
        end else begin
            was_stalled = 0;
        end
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        #5;
        check(m_tvalid == 1'b0, "R10 reset valid", {31'b0, m_tvalid}, 32'd0);
        check(s_tready == 1'b1, "R7 reset ready", {31'b0, s_tready}, 32'd1);
        @(negedge clk);
        rst = 1'b0;

        // R1 passthrough with unity gain (16384 = 1.0 in Q2.14)
        set_coefs(16384, 0, 0, 0, 0);
        send(16'h1234, -5, 0, "R1 packing");
        send(-32768, 32767, 1, "R1 extremes");
        drain();

        // R3 rounding: gain 1/16384
        set_coefs(1, 0, 0, 0, 0);
        send(8192, 8191, 0, "R3 half up / below half");
        send(-8192, -8193, 0, "R3 negative half");
        drain();

        // R4 saturation: gain ~2
        set_coefs(32767, 0, 0, 0, 0);
        send(30000, -30000, 0, "R4 saturate");
        send(-32768, 32767, 1, "R4 saturate swap");
        drain();

        // R4 saturated value fed back: y term uses clamped output
        set_coefs(16384, 0, 0, -16384, 0);
        send(30000, -30000, 0, "R4 feedback clamp");
        send(30000, -30000, 0, "R4 feedback clamp");
        send(0, 0, 0, "R4 feedback clamp");
        drain();

        // R2 R5 general filter, left only
        set_coefs(4096, 8192, 4096, -8000, 3000);
        for (int i = 0; i < 20; i++) send(i * 1500 - 9000, 0, 0, "R2 R5 one-sided");
        drain();

        // R2 R8 R9 random streaming with backpressure and gaps
        ready_mode = 1;
        for (int i = 0; i < 300; i++) begin
            send($urandom_range(0, 65535), $urandom_range(0, 65535), $urandom_range(0, 1), "R2 R9 random");
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
        drain();
        ready_mode = 0;
        idle(3);

        // R10 reset mid-stream clears history
        set_coefs(16384, 16384, 16384, 0, 0);
        send(1000, -1000, 0, "R10 prefill");
        send(2000, -2000, 0, "R10 prefill");
        drain();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #5;
        check(m_tvalid == 1'b0, "R10 valid after reset", {31'b0, m_tvalid}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        clear_model();
        send(100, -100, 1, "R10 cleared history");
        drain();

        done = 1;
        check(q.size() == 0, "R6 queue drained", q.size(), 0);
        summary();
    end
endmodule